// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequencer

This block sits between a host and a 16-bit parallel NOR flash bus. The host hands it one request at a time: program a single halfword, erase one block, or bring every block to a known state at start-up. The sequencer turns each request into an ordered series of one-cycle command writes to the flash. It polls the status word until the device reports ready, returns the device to array-read mode, and answers with a one-cycle response that carries an error flag.

A long erase need not block the system. If the interrupt-pending input is high while the erase is still running, the sequencer suspends the erase. It returns the device to array-read mode and raises `susp_ack`. While `susp_ack` is high the host owns the flash bus. When the host pulses `resume_req`, the sequencer restarts the erase with a resume command followed by an extra status-read command, then goes back to polling. A poll that never sees ready within `POLL_LIMIT` reads is abandoned with an error response.

Addresses count halfwords. Block `k` starts at `k * BLK_WORDS`, and there are `NBLK` blocks. For an erase, the block index is taken from the low bits of `req_addr`.

Top module: `flash_seq`

## Requirements
- R1: A program request (`req_op` = 00) at address A with word D first reads A once. If allowed, it writes 0x0060, 0x00D0, 0x0050, 0x0040 and then D, all at A. It then reads status at A until bit 7 is 1, writes 0x00FF, and responds with `resp_err` = 0.
- R2: A program request is refused when (~current_word & D) is nonzero, meaning it would need to turn a 0 bit into a 1. A refused request makes exactly one read, no write, and responds with `resp_err` = 1.
- R3: An erase request (`req_op` = 01) of block k writes, at k*BLK_WORDS, the words 0x0060, 0x00D0, 0x0050, 0x0020, 0x00D0 and 0x0070. It then polls status bit 7, writes 0x00FF and responds without error.
- R4: If `irq_pend` is 1 during an erase poll read whose bit 7 is 0, the next writes are 0x00B0 and then 0x0070. Status is then polled until bit 7 is 1.
- R5: If that suspend poll returns bit 6 = 0, the erase is already complete. The sequencer writes 0x00FF and responds without error, and `susp_ack` never rises.
- R6: If the suspend poll returns bit 6 = 1, the sequencer writes 0x00FF and then holds `susp_ack` high. While `susp_ack` is high it makes no bus read or write, until it sees `resume_req`.
- R7: `resume_req` while `susp_ack` is high causes a write of 0x00D0 in the next cycle and 0x0070 in the cycle after that. Erase polling then continues, and the erase ends with 0x00FF and a good response.
- R8: An initialise request (`req_op` = 10) handles blocks 0 to NBLK-1 in order, each at its base address. For each block it writes 0x0050, 0x00FF, 0x0060 and 0x00D0, polls until bit 7 is 1, and writes 0x0070. It then reads status: if bit 6 is 1 it writes 0x00D0 and polls until bit 7 is 1. It finishes the block with 0x00FF. One response follows the last block.
- R9: If a poll sees bit 7 = 0 on POLL_LIMIT consecutive reads, the operation is abandoned. The sequencer writes 0x00FF and responds with `resp_err` = 1.
- R10: `req_ready` is high only when idle, and each accepted request gets exactly one `resp_valid` pulse. The reserved code `req_op` = 11 responds with `resp_err` = 1 and makes no bus access.
- R11: After reset, `req_ready` = 1 and `bus_we`, `bus_re`, `resp_valid` and `susp_ack` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken when `req_ready` is high |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_op | input | 2 | 00 program, 01 erase, 10 initialise, 11 reserved |
| req_addr | input | AW | Halfword address (program) or block index in low bits (erase) |
| req_data | input | 16 | Word to program |
| resp_valid | output | 1 | One-cycle completion pulse |
| resp_err | output | 1 | Error flag, valid with `resp_valid` |
| irq_pend | input | 1 | Interrupt pending; suspends a running erase |
| susp_ack | output | 1 | Erase suspended, bus handed to the host |
| resume_req | input | 1 | Host done; resume the suspended erase |
| bus_addr | output | AW | Flash halfword address |
| bus_wdata | output | 16 | Flash write word |
| bus_we | output | 1 | One-cycle flash write strobe |
| bus_re | output | 1 | Flash read strobe; `bus_rdata` is sampled in the same cycle |
| bus_rdata | input | 16 | Flash read word (status or array data) |

## Verification
The assertions assume several things about the inputs. `resume_req` matters only while `susp_ack` is high. `bus_rdata` is valid in the same cycle as `bus_re`. The host holds no request while the sequencer is busy.

The bench keeps within these limits. It pulses `resume_req` only after it sees `susp_ack`. It drives `bus_rdata` combinationally from a small flash model whose status bits follow the commands written to it. It issues a new request only when `req_ready` is high, and it lowers `irq_pend` once the erase is parked so that each erase is suspended at most once.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

    localparam int WORD_W = 16;

    typedef enum logic [1:0] {
        OP_PROG  = 2'd0,
        OP_ERASE = 2'd1,
        OP_INIT  = 2'd2,
        OP_RSVD  = 2'd3
    } op_e;

    // command scripts the sequencer can play
    typedef enum logic [2:0] {
        SQ_PROG,
        SQ_ERASE,
        SQ_SUSP,
        SQ_RESUME,
        SQ_INIT,
        SQ_STAT,
        SQ_WAKE,
        SQ_ARRAY
    } seq_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RDCHK,
        ST_SEQ,
        ST_POLL,
        ST_SPOLL,
        ST_ISTAT,
        ST_HOLD,
        ST_RESP
    } st_e;

    // what a completed poll leads to
    typedef enum logic [1:0] {
        PM_PROG,
        PM_ERASE,
        PM_INIT_UNL,
        PM_INIT_WAKE
    } pm_e;

endpackage

// File: rtl/flash_seq_cmd.sv
module flash_seq_cmd
    import flash_seq_pkg::*;
(
    input  seq_e              seq,
    input  logic [2:0]        idx,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] word,
    output logic              last
);
    always_comb begin
        word = 16'h00FF;
        last = 1'b1;
        case (seq)
            SQ_PROG: begin
                last = (idx == 3'd4);
                case (idx)
                    3'd0:    word = 16'h0060;
                    3'd1:    word = 16'h00D0;
                    3'd2:    word = 16'h0050;
                    3'd3:    word = 16'h0040;
                    default: word = wdata;
                endcase
            end
            SQ_ERASE: begin
                last = (idx == 3'd5);
                case (idx)
                    3'd0:    word = 16'h0060;
                    3'd1:    word = 16'h00D0;
                    3'd2:    word = 16'h0050;
                    3'd3:    word = 16'h0020;
                    3'd4:    word = 16'h00D0;
                    default: word = 16'h0070;
                endcase
            end
            SQ_SUSP: begin
                last = (idx == 3'd1);
                word = (idx == 3'd0) ? 16'h00B0 : 16'h0070;
            end
            SQ_RESUME: begin
                last = (idx == 3'd1);
                word = (idx == 3'd0) ? 16'h00D0 : 16'h0070;
            end
            SQ_INIT: begin
                last = (idx == 3'd3);
                case (idx)
                    3'd0:    word = 16'h0050;
                    3'd1:    word = 16'h00FF;
                    3'd2:    word = 16'h0060;
                    default: word = 16'h00D0;
                endcase
            end
            SQ_STAT:  word = 16'h0070;
            SQ_WAKE:  word = 16'h00D0;
            default:  word = 16'h00FF;
        endcase
    end
endmodule

// File: rtl/flash_seq_timer.sv
module flash_seq_timer #(
    parameter int LIMIT = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    output logic expired
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    assign expired = run && (cnt_q == CW'(LIMIT - 1));

    always_comb begin
        cnt_d = cnt_q;
        if (clear)
            cnt_d = '0;
        else if (run && !expired)
            cnt_d = cnt_q + CW'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/flash_seq.sv
module flash_seq
    import flash_seq_pkg::*;
#(
    parameter int AW         = 20,
    parameter int NBLK       = 16,
    parameter int BLK_WORDS  = 65536,
    parameter int POLL_LIMIT = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_op,
    input  logic [AW-1:0]     req_addr,
    input  logic [WORD_W-1:0] req_data,
    output logic              resp_valid,
    output logic              resp_err,
    input  logic              irq_pend,
    output logic              susp_ack,
    input  logic              resume_req,
    output logic [AW-1:0]     bus_addr,
    output logic [WORD_W-1:0] bus_wdata,
    output logic              bus_we,
    output logic              bus_re,
    input  logic [WORD_W-1:0] bus_rdata
);
    localparam int BW = (NBLK > 1) ? $clog2(NBLK) : 1;
    localparam logic [BW-1:0] LAST_BLK = BW'(NBLK - 1);

    typedef struct packed {
        st_e               st;
        seq_e              seq;
        logic [2:0]        idx;
        pm_e               mode;
        logic              park;
        logic              err;
        logic [AW-1:0]     addr;
        logic [WORD_W-1:0] data;
        logic [BW-1:0]     blk;
    } ctl_t;

    ctl_t q, n;

    logic [WORD_W-1:0] cmd_word;
    logic              cmd_last;
    logic              polling, tmo;

    function automatic logic [AW-1:0] blk_base(input logic [BW-1:0] b);
        return AW'(b) * AW'(BLK_WORDS);
    endfunction

    flash_seq_cmd u_cmd (
        .seq   (q.seq),
        .idx   (q.idx),
        .wdata (q.data),
        .word  (cmd_word),
        .last  (cmd_last)
    );

    assign polling = (q.st == ST_POLL) || (q.st == ST_SPOLL);

    flash_seq_timer #(.LIMIT(POLL_LIMIT)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (!polling),
        .run     (polling && !bus_rdata[7]),
        .expired (tmo)
    );

    always_comb begin
        n = q;
        case (q.st)
            ST_IDLE: if (req_valid) begin
                n.err  = 1'b0;
                n.park = 1'b0;
                n.idx  = '0;
                n.data = req_data;
                case (op_e'(req_op))
                    OP_PROG: begin
                        n.addr = req_addr;
                        n.st   = ST_RDCHK;
                    end
                    OP_ERASE: begin
                        n.addr = blk_base(req_addr[BW-1:0]);
                        n.seq  = SQ_ERASE;
                        n.st   = ST_SEQ;
                    end
                    OP_INIT: begin
                        n.blk  = '0;
                        n.addr = '0;
                        n.seq  = SQ_INIT;
                        n.mode = PM_INIT_UNL;
                        n.st   = ST_SEQ;
                    end
                    default: begin
                        n.err = 1'b1;
                        n.st  = ST_RESP;
                    end
                endcase
            end
            ST_RDCHK: begin
                if ((~bus_rdata & q.data) != '0) begin
                    n.err = 1'b1;
                    n.st  = ST_RESP;
                end else begin
                    n.seq = SQ_PROG;
                    n.st  = ST_SEQ;
                end
            end
            ST_SEQ: begin
                if (!cmd_last) begin
                    n.idx = q.idx + 3'd1;
                end else begin
                    n.idx = '0;
                    case (q.seq)
                        SQ_PROG:   begin n.mode = PM_PROG;      n.st = ST_POLL; end
                        SQ_ERASE,
                        SQ_RESUME: begin n.mode = PM_ERASE;     n.st = ST_POLL; end
                        SQ_SUSP:   n.st = ST_SPOLL;
                        SQ_INIT:   begin n.mode = PM_INIT_UNL;  n.st = ST_POLL; end
                        SQ_STAT:   n.st = ST_ISTAT;
                        SQ_WAKE:   begin n.mode = PM_INIT_WAKE; n.st = ST_POLL; end
                        default: begin
                            if (q.park) begin
                                n.st = ST_HOLD;
                            end else if ((q.mode == PM_INIT_UNL || q.mode == PM_INIT_WAKE)
                                         && !q.err && q.blk != LAST_BLK) begin
                                n.blk  = q.blk + BW'(1);
                                n.addr = blk_base(q.blk + BW'(1));
                                n.seq  = SQ_INIT;
                                n.mode = PM_INIT_UNL;
                                n.st   = ST_SEQ;
                            end else begin
                                n.st = ST_RESP;
                            end
                        end
                    endcase
                end
            end
            ST_POLL: begin
                if (bus_rdata[7]) begin
                    n.seq = (q.mode == PM_INIT_UNL) ? SQ_STAT : SQ_ARRAY;
                    n.st  = ST_SEQ;
                end else if (tmo) begin
                    n.err = 1'b1;
                    n.seq = SQ_ARRAY;
                    n.st  = ST_SEQ;
                end else if (q.mode == PM_ERASE && irq_pend) begin
                    n.seq = SQ_SUSP;
                    n.st  = ST_SEQ;
                end
            end
            ST_SPOLL: begin
                if (bus_rdata[7]) begin
                    n.park = bus_rdata[6];
                    n.seq  = SQ_ARRAY;
                    n.st   = ST_SEQ;
                end else if (tmo) begin
                    n.err = 1'b1;
                    n.seq = SQ_ARRAY;
                    n.st  = ST_SEQ;
                end
            end
            ST_ISTAT: begin
                n.seq = bus_rdata[6] ? SQ_WAKE : SQ_ARRAY;
                n.st  = ST_SEQ;
            end
            ST_HOLD: if (resume_req) begin
                n.park = 1'b0;
                n.seq  = SQ_RESUME;
                n.st   = ST_SEQ;
            end
            ST_RESP: n.st = ST_IDLE;
            default: n.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    assign req_ready  = (q.st == ST_IDLE);
    assign resp_valid = (q.st == ST_RESP);
    assign resp_err   = resp_valid && q.err;
    assign susp_ack   = (q.st == ST_HOLD);
    assign bus_addr   = q.addr;
    assign bus_we     = (q.st == ST_SEQ);
    assign bus_wdata  = bus_we ? cmd_word : '0;
    assign bus_re     = (q.st == ST_RDCHK) || polling || (q.st == ST_ISTAT);

    // R10
    resp_then_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> req_ready);

    // R10
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R1 R3 R8
    good_end_array_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && !resp_err) |-> ($past(bus_we) && $past(bus_wdata) == 16'h00FF));

    // R6
    park_after_array_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(susp_ack) |-> ($past(bus_we) && $past(bus_wdata) == 16'h00FF));

    // R7
    resume_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (susp_ack && resume_req) |=> (bus_we && bus_wdata == 16'h00D0));

    // R7
    resume_stat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(susp_ack && resume_req, 2) |-> (bus_we && bus_wdata == 16'h0070));

endmodule

// File: tb/flash_seq_tb.sv
module flash_seq_tb;
    localparam int AW = 10, NBLK = 4, BLKW = 64, LIM = 64;
    localparam int ULAT = 3, PLAT = 4, ELAT = 30;

    logic clk = 1'b0, rst_n = 1'b0;
    always #5 clk = ~clk;

    logic req_valid = 0, resume_req = 0, irq_pend = 0;
    logic [1:0] req_op = 0;
    logic [AW-1:0] req_addr = 0;
    logic [15:0] req_data = 0;
    logic req_ready, resp_valid, resp_err, susp_ack, bus_we, bus_re;
    logic [AW-1:0] bus_addr;
    logic [15:0] bus_wdata, bus_rdata;

    flash_seq #(.AW(AW), .NBLK(NBLK), .BLK_WORDS(BLKW), .POLL_LIMIT(LIM)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_addr(req_addr), .req_data(req_data),
        .resp_valid(resp_valid), .resp_err(resp_err), .irq_pend(irq_pend),
        .susp_ack(susp_ack), .resume_req(resume_req), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata));

    // ---------------- flash model ----------------
    logic [15:0] fmem [256];
    logic smode, susp;
    logic [15:0] prev;
    int ubusy, ebusy;
    logic [1:0] eblk;
    logic hang = 0, fin_on_susp = 0, preset_req = 0;
    logic [AW-1:0] lg_a [256];
    logic [15:0]   lg_d [256];
    int lg_n, rd_n, ack_n;
    logic rdy;

    assign rdy = (ubusy == 0) && (susp || ebusy == 0);
    assign bus_rdata = smode ? {8'h00, rdy, susp, 6'h00} : fmem[bus_addr[7:0]];

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) fmem[i] <= 16'hFFFF;
            smode <= 0; susp <= 0; prev <= 0; ubusy <= 0; ebusy <= 0; eblk <= 0;
            lg_n <= 0; rd_n <= 0; ack_n <= 0;
        end else begin
            if (bus_re) rd_n <= rd_n + 1;
            if (susp_ack) ack_n <= ack_n + 1;
            if (ubusy != 0 && !hang) ubusy <= ubusy - 1;
            if (ebusy != 0 && !susp && !hang) begin
                ebusy <= ebusy - 1;
                if (ebusy == 1)
                    for (int i = 0; i < 64; i++) fmem[{eblk, 6'(i)}] <= 16'hFFFF;
            end
            if (preset_req) begin susp <= 1; ebusy <= 10; eblk <= 2'd1; end
            if (bus_we) begin
                lg_a[lg_n % 256] <= bus_addr;
                lg_d[lg_n % 256] <= bus_wdata;
                lg_n <= lg_n + 1;
                prev <= bus_wdata;
                if (prev == 16'h0040) begin
                    fmem[bus_addr[7:0]] <= fmem[bus_addr[7:0]] & bus_wdata;
                    ubusy <= PLAT; smode <= 1; prev <= 16'h0000;
                end else begin
                    case (bus_wdata)
                        16'h00FF: smode <= 0;
                        16'h0070: smode <= 1;
                        16'h00D0: begin
                            smode <= 1;
                            if (prev == 16'h0060) ubusy <= ULAT;
                            else if (prev == 16'h0020) begin ebusy <= ELAT; eblk <= bus_addr[7:6]; end
                            else susp <= 0;
                        end
                        16'h00B0: begin
                            smode <= 1;
                            if (ebusy != 0 && !fin_on_susp) susp <= 1;
                            else if (ebusy != 0) begin
                                ebusy <= 0;
                                for (int i = 0; i < 64; i++) fmem[{eblk, 6'(i)}] <= 16'hFFFF;
                            end
                        end
                        default: ;
                    endcase
                end
            end
        end
    end

    // ---------------- checking ----------------
    int n_chk = 0, n_bad = 0;
    int base, rbase, abase, ex_n;
    logic [AW-1:0] ex_a [64];
    logic [15:0]   ex_d [64];
    logic got_err;

    task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    task automatic push(input logic [AW-1:0] a, input logic [15:0] d);
        ex_a[ex_n] = a; ex_d[ex_n] = d; ex_n++;
    endtask

    task automatic check_log(input string rq);
        int got, bad;
        got = lg_n - base;
        bad = -1;
        if (got == ex_n)
            for (int k = 0; k < ex_n; k++)
                if (bad < 0 && (lg_a[(base + k) % 256] != ex_a[k] || lg_d[(base + k) % 256] != ex_d[k]))
                    bad = k;
        n_chk++;
        if (got != ex_n) begin
            n_bad++;
            $display("FAIL %s write count: actual %0d expected %0d", rq, got, ex_n);
        end else if (bad >= 0) begin
            n_bad++;
            $display("FAIL %s write %0d: actual %h@%h expected %h@%h", rq, bad,
                     lg_d[(base + bad) % 256], lg_a[(base + bad) % 256], ex_d[bad], ex_a[bad]);
        end
    endtask

    task automatic begin_op();
        base = lg_n; rbase = rd_n; abase = ack_n; ex_n = 0;
    endtask

    task automatic issue(input logic [1:0] op, input logic [AW-1:0] a, input logic [15:0] d);
        while (!req_ready) @(negedge clk);
        req_valid = 1; req_op = op; req_addr = a; req_data = d;
        @(negedge clk);
        req_valid = 0;
    endtask

    task automatic wait_resp();
        while (!resp_valid) @(negedge clk);
        got_err = resp_err;
        @(negedge clk);
    endtask

    task automatic prog_op(input logic [AW-1:0] a, input logic [15:0] d);
        logic exp_err;
        exp_err = ((~fmem[a[7:0]] & d) != 0);
        begin_op();
        if (!exp_err) begin
            push(a, 16'h0060); push(a, 16'h00D0); push(a, 16'h0050);
            push(a, 16'h0040); push(a, d); push(a, 16'h00FF);
        end
        issue(2'b00, a, d);
        wait_resp();
        if (exp_err) begin
            chk(got_err == 1, "R2", "reject flag", got_err, 1);
            chk(rd_n - rbase == 1, "R2", "reads on reject", rd_n - rbase, 1);
            check_log("R2");
        end else begin
            chk(got_err == 0, "R1", "program flag", got_err, 0);
            check_log("R1");
        end
    endtask

    task automatic erase_op(input int b, input bit irq, input bit fin);
        logic [AW-1:0] ba;
        ba = AW'(b * BLKW);
        fin_on_susp = fin;
        irq_pend = irq;
        begin_op();
        push(ba, 16'h0060); push(ba, 16'h00D0); push(ba, 16'h0050);
        push(ba, 16'h0020); push(ba, 16'h00D0); push(ba, 16'h0070);
        if (irq) begin push(ba, 16'h00B0); push(ba, 16'h0070); end
        if (irq && !fin) begin push(ba, 16'h00FF); push(ba, 16'h00D0); push(ba, 16'h0070); end
        push(ba, 16'h00FF);
        issue(2'b01, AW'(b), 16'h0);
        if (irq && !fin) begin
            while (!susp_ack && !resp_valid) @(negedge clk);
            chk(susp_ack == 1, "R4", "erase parked", susp_ack, 1);
            for (int i = 0; i < 3; i++) begin
                chk(susp_ack && !bus_we && !bus_re, "R6", "quiet while parked",
                    {susp_ack, bus_we, bus_re}, 3'b100);
                @(negedge clk);
            end
            irq_pend = 0;
            resume_req = 1;
            @(negedge clk);
            resume_req = 0;
        end
        wait_resp();
        irq_pend = 0;
        chk(got_err == 0, irq ? "R7" : "R3", "erase flag", got_err, 0);
        check_log(irq ? (fin ? "R5" : "R7") : "R3");
        if (irq && fin) chk(ack_n == abase, "R5", "no handback", ack_n - abase, 0);
    endtask

    task automatic init_op(input bit preset);
        if (preset) begin
            @(negedge clk); preset_req = 1; @(negedge clk); preset_req = 0;
        end
        begin_op();
        for (int b = 0; b < NBLK; b++) begin
            push(AW'(b * BLKW), 16'h0050); push(AW'(b * BLKW), 16'h00FF);
            push(AW'(b * BLKW), 16'h0060); push(AW'(b * BLKW), 16'h00D0);
            push(AW'(b * BLKW), 16'h0070);
            if (preset && b == 0) push(AW'(b * BLKW), 16'h00D0);
            push(AW'(b * BLKW), 16'h00FF);
        end
        issue(2'b10, '0, 16'h0);
        wait_resp();
        chk(got_err == 0, "R8", "init flag", got_err, 0);
        check_log("R8");
    endtask

    initial begin
        int unsigned r;
        r = $urandom(32'd24681);
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R11
        chk(req_ready == 1, "R11", "ready after reset", req_ready, 1);
        chk({bus_we, bus_re, resp_valid, susp_ack} == 4'b0, "R11", "quiet after reset",
            {bus_we, bus_re, resp_valid, susp_ack}, 0);

        prog_op(10'd5, 16'h1234);          // R1
        prog_op(10'd5, 16'h0001);          // R2: 0 -> 1
        // R10 reserved code
        begin_op();
        issue(2'b11, 10'd3, 16'h0);
        wait_resp();
        chk(got_err == 1, "R10", "reserved flag", got_err, 1);
        chk(rd_n == rbase, "R10", "reserved reads", rd_n - rbase, 0);
        check_log("R10");

        erase_op(2, 0, 0);                 // R3
        erase_op(1, 1, 1);                 // R5
        erase_op(3, 1, 0);                 // R4 R6 R7
        init_op(1);                        // R8 with suspended erase
        init_op(0);                        // R8 plain

        // R9 timeout
        hang = 1;
        begin_op();
        push(10'd7, 16'h0060); push(10'd7, 16'h00D0); push(10'd7, 16'h0050);
        push(10'd7, 16'h0040); push(10'd7, 16'h00FF); push(10'd7, 16'h00FF);
        issue(2'b00, 10'd7, 16'h00FF);
        wait_resp();
        chk(got_err == 1, "R9", "timeout flag", got_err, 1);
        chk(rd_n - rbase == LIM + 1, "R9", "poll reads", rd_n - rbase, LIM + 1);
        check_log("R9");
        hang = 0;
        repeat (20) @(negedge clk);

        for (int it = 0; it < 40; it++) begin
            r = $urandom % 4;
            if (r < 2) begin
                logic [AW-1:0] a;
                logic [15:0] d;
                a = AW'($urandom % 256);
                d = 16'($urandom);
                if ($urandom % 2) d = d & fmem[a[7:0]];
                prog_op(a, d);
            end else begin
                int b;
                bit ir, fn;
                b = int'($urandom % NBLK);
                ir = 1'($urandom);
                fn = 1'($urandom);
                erase_op(b, ir, fn);
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule